// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small processor core without pipelining. Each instruction completes in one clock cycle. The program counter addresses an instruction memory. The fetched word is decoded, and the register file supplies two operands. One adder produces either a data address, an arithmetic result or a jump target. The data memory is read or written, and the result goes back to the register file on the clock edge that ends the instruction. The instruction memory and the data memory are outside the block, and both are read combinationally: a read value depends only on the address driven in the same cycle.

The instruction set covers the following:
- loads with two-register or register-plus-literal addressing
- a register-plus-literal store
- addition with a register or a literal second operand
- a conditional branch relative to the program counter, taken when the zero flag is set
- a jump to a register-plus-literal address

The next program counter comes from a three-way selector: the incremented value, the branch target, or the adder output. Register write data comes from a second selector: the adder output or the data-memory read data.

Top module: `flow_core`

## Requirements
- R1: Instruction fields: opcode [31:28], destination D [27:24], source S1 [23:20], source S2 [19:16], signed literal L [15:0]. Opcodes: 0 = no operation, 1 = indexed load, 2 = offset load, 3 = store, 4 = add register, 5 = add literal, 6 = branch-if-zero, 7 = jump. Opcodes 8 to 15 also act as no operation. Every register index 0 to 15 is an ordinary writable register.
- R2: Opcode 1 writes D with the data word read at address S1 + S2.
- R3: Opcode 2 writes D with the data word read at address S1 + sign-extended L.
- R4: Opcode 3 drives dmem_addr = S1 + sign-extended L and dmem_wdata = S2, and asserts dmem_we. dmem_we is asserted for no other opcode.
- R5: Opcode 4 writes D = S1 + S2, and opcode 5 writes D = S1 + sign-extended L, both modulo 2^32.
- R6: Opcode 6 with the zero flag set loads the program counter with PC + 4 + (sign-extended L shifted left by 2).
- R7: Opcode 6 with the zero flag clear loads the program counter with PC + 4.
- R8: Opcode 7 loads the program counter with S1 + sign-extended L.
- R9: The zero flag is updated only by opcodes 4 and 5, to 1 exactly when the sum is zero. All other opcodes leave it unchanged. Reset clears it.
- R10: While rst_n is low, imem_addr is 0 and dmem_we is 0, and reset clears all registers. Every opcode other than 6 and 7 advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data memory byte address, which is the adder output |
| dmem_wdata | output | 32 | Store data, which is the S2 register value |
| dmem_we | output | 1 | Data memory write enable, asserted for stores |
| dmem_rdata | input | 32 | Data word at dmem_addr |

## Verification
A store shows its address and data on the data port in the same cycle in which it is fetched. The bench therefore samples each store at the falling edge of that cycle.

Loads, adds and branches are not visible at the port directly. Their effects are brought out through later stores, through the order of stores, and through whether instructions placed in skipped code write anything. A register or flag written at the rising edge that ends one instruction is first observed by the instruction that follows it.

A new program counter value appears on imem_addr one rising edge after the branch or jump that chose it. The bench reads the final value only once the program has reached its closing self-jump.

// File: rtl/core_pkg.sv
package core_pkg;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_LDX = 4'd1,
        OP_LDO = 4'd2,
        OP_STO = 4'd3,
        OP_ADR = 4'd4,
        OP_ADL = 4'd5,
        OP_BEQ = 4'd6,
        OP_JMP = 4'd7
    } opcode_e;

    typedef enum logic [1:0] {
        PC_INC = 2'd0,
        PC_BR  = 2'd1,
        PC_ALU = 2'd2
    } pc_sel_e;

    typedef struct packed {
        logic    reg_we;
        logic    wb_mem;
        logic    b_lit;
        logic    mem_we;
        logic    flag_we;
        logic    is_branch;
        logic    is_jump;
    } ctrl_t;

endpackage

// File: rtl/core_decode.sv
module core_decode
    import core_pkg::*;
(
    input  logic [3:0] opcode,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (opcode)
            OP_LDX: begin
                ctrl.reg_we = 1'b1;
                ctrl.wb_mem = 1'b1;
            end
            OP_LDO: begin
                ctrl.reg_we = 1'b1;
                ctrl.wb_mem = 1'b1;
                ctrl.b_lit  = 1'b1;
            end
            OP_STO: begin
                ctrl.mem_we = 1'b1;
                ctrl.b_lit  = 1'b1;
            end
            OP_ADR: begin
                ctrl.reg_we  = 1'b1;
                ctrl.flag_we = 1'b1;
            end
            OP_ADL: begin
                ctrl.reg_we  = 1'b1;
                ctrl.flag_we = 1'b1;
                ctrl.b_lit   = 1'b1;
            end
            OP_BEQ: begin
                ctrl.is_branch = 1'b1;
            end
            OP_JMP: begin
                ctrl.is_jump = 1'b1;
                ctrl.b_lit   = 1'b1;
            end
            default: begin
                ctrl = '0;
            end
        endcase
    end

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
    parameter int XLEN = 32,
    parameter int RAW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RAW-1:0]  rd_a_idx,
    input  logic [RAW-1:0]  rd_b_idx,
    output logic [XLEN-1:0] rd_a_val,
    output logic [XLEN-1:0] rd_b_val,
    input  logic            wr_en,
    input  logic [RAW-1:0]  wr_idx,
    input  logic [XLEN-1:0] wr_val
);

    localparam int NREG = 1 << RAW;

    logic [XLEN-1:0] regs_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_en) begin
            regs_q[wr_idx] <= wr_val;
        end
    end

    assign rd_a_val = regs_q[rd_a_idx];
    assign rd_b_val = regs_q[rd_b_idx];

endmodule

// File: rtl/core_nextpc.sv
module core_nextpc
    import core_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] lit_ext,
    input  logic [XLEN-1:0] alu_y,
    input  pc_sel_e         sel,
    output logic [XLEN-1:0] pc_next
);

    logic [XLEN-1:0] pc_inc;
    logic [XLEN-1:0] br_tgt;

    assign pc_inc = pc + XLEN'(4);
    assign br_tgt = pc_inc + {lit_ext[XLEN-3:0], 2'b00};

    always_comb begin
        unique case (sel)
            PC_BR:   pc_next = br_tgt;
            PC_ALU:  pc_next = alu_y;
            default: pc_next = pc_inc;
        endcase
    end

endmodule

// File: rtl/flow_core.sv
module flow_core
    import core_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RAW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam int D_LSB  = 28 - RAW;
    localparam int S1_LSB = D_LSB - RAW;
    localparam int S2_LSB = S1_LSB - RAW;
    localparam int LITW   = S2_LSB;

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_next;
    logic            z_q;
    ctrl_t           ctrl;
    pc_sel_e         pc_sel;

    logic [RAW-1:0]  f_d;
    logic [RAW-1:0]  f_s1;
    logic [RAW-1:0]  f_s2;
    logic [LITW-1:0] f_lit;
    logic [XLEN-1:0] lit_ext;
    logic [XLEN-1:0] src_a;
    logic [XLEN-1:0] src_b;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] wb_val;

    assign f_d     = imem_rdata[D_LSB +: RAW];
    assign f_s1    = imem_rdata[S1_LSB +: RAW];
    assign f_s2    = imem_rdata[S2_LSB +: RAW];
    assign f_lit   = imem_rdata[LITW-1:0];
    assign lit_ext = {{(XLEN-LITW){f_lit[LITW-1]}}, f_lit};

    core_decode u_decode (
        .opcode (imem_rdata[31:28]),
        .ctrl   (ctrl)
    );

    core_regfile #(.XLEN(XLEN), .RAW(RAW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (f_s1),
        .rd_b_idx (f_s2),
        .rd_a_val (src_a),
        .rd_b_val (src_b),
        .wr_en    (ctrl.reg_we),
        .wr_idx   (f_d),
        .wr_val   (wb_val)
    );

    // one adder serves addresses, sums and jump targets
    assign alu_b  = ctrl.b_lit ? lit_ext : src_b;
    assign alu_y  = src_a + alu_b;
    assign wb_val = ctrl.wb_mem ? dmem_rdata : alu_y;

    always_comb begin
        if (ctrl.is_jump) begin
            pc_sel = PC_ALU;
        end else if (ctrl.is_branch && z_q) begin
            pc_sel = PC_BR;
        end else begin
            pc_sel = PC_INC;
        end
    end

    core_nextpc #(.XLEN(XLEN)) u_nextpc (
        .pc      (pc_q),
        .lit_ext (lit_ext),
        .alu_y   (alu_y),
        .sel     (pc_sel),
        .pc_next (pc_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            z_q  <= 1'b0;
        end else begin
            pc_q <= pc_next;
            if (ctrl.flag_we) begin
                z_q <= (alu_y == '0);
            end
        end
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = src_b;
    assign dmem_we    = ctrl.mem_we & rst_n;

endmodule

// File: rtl/core_chk.sv
module core_chk
    import core_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RAW  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] imem_addr,
    input logic [31:0]     imem_rdata,
    input logic [XLEN-1:0] dmem_addr,
    input logic            dmem_we,
    input logic            z_flag
);

    localparam int LITW = 28 - 3 * RAW;

    logic [3:0]      op;
    logic [XLEN-1:0] boff;

    assign op   = imem_rdata[31:28];
    assign boff = {{(XLEN-LITW-2){imem_rdata[LITW-1]}}, imem_rdata[LITW-1:0], 2'b00};

    // R4
    store_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we == (op == OP_STO));

    // R10
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_BEQ && op != OP_JMP) |=> imem_addr == $past(imem_addr) + XLEN'(4));

    // R7
    br_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BEQ && !z_flag) |=> imem_addr == $past(imem_addr) + XLEN'(4));

    // R6
    br_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BEQ && z_flag) |=> imem_addr == $past(imem_addr) + XLEN'(4) + $past(boff));

    // R8
    jmp_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_JMP) |=> imem_addr == $past(dmem_addr));

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_ADR && op != OP_ADL) |=> $stable(z_flag));

endmodule

bind flow_core core_chk #(.XLEN(XLEN), .RAW(RAW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_we    (dmem_we),
    .z_flag     (z_q)
);

// File: tb/test_flow_core.sv
module test_flow_core;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic [31:0] dmem_rdata;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_addr [$];
    logic [31:0] exp_data [$];
    string       exp_req  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flow_core i_flow_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc(input int op, input int d, input int s1,
                                        input int s2, input logic [15:0] lit);
        return {op[3:0], d[3:0], s1[3:0], s2[3:0], lit};
    endfunction

    task automatic push_exp(input logic [31:0] a, input logic [31:0] v, input string req);
        exp_addr.push_back(a);
        exp_data.push_back(v);
        exp_req.push_back(req);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, expv);
        end
    endtask

    // monitor: every store is compared against the next expected item
    always @(negedge clk) begin
        if (rst_n && dmem_we) begin
            if (exp_addr.size() == 0) begin
                check(1'b0, "R4 unexpected store", dmem_addr, 32'h0);
            end else begin
                logic [31:0] ea;
                logic [31:0] ed;
                string       er;
                ea = exp_addr.pop_front();
                ed = exp_data.pop_front();
                er = exp_req.pop_front();
                check(dmem_addr == ea, {er, " addr"}, dmem_addr, ea);
                check(dmem_wdata == ed, {er, " data"}, dmem_wdata, ed);
            end
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
        dmem[4]  = 32'd100;
        dmem[5]  = 32'd7;
        dmem[10] = 32'hDEAD_BEEF;

        imem[0]  = enc(5, 1, 0, 0, 16'd16);
        imem[1]  = enc(2, 2, 1, 0, 16'd4);
        imem[2]  = enc(5, 3, 0, 0, 16'd24);
        imem[3]  = enc(1, 4, 1, 3, 16'd0);
        imem[4]  = enc(3, 0, 0, 4, 16'd128);
        imem[5]  = enc(3, 0, 1, 2, 16'hFFFC);
        imem[6]  = enc(4, 5, 2, 4, 16'd0);
        imem[7]  = enc(3, 0, 0, 5, 16'd132);
        imem[8]  = enc(6, 0, 0, 0, 16'd3);
        imem[9]  = enc(5, 6, 2, 0, 16'hFFF9);
        imem[10] = enc(2, 7, 0, 0, 16'd16);
        imem[11] = enc(6, 0, 0, 0, 16'd2);
        imem[12] = enc(3, 0, 0, 2, 16'd200);
        imem[13] = enc(3, 0, 0, 2, 16'd200);
        imem[14] = enc(3, 0, 0, 7, 16'd136);
        imem[15] = enc(5, 8, 0, 0, 16'd80);
        imem[16] = enc(7, 0, 8, 0, 16'd8);
        for (int i = 17; i < 22; i++) imem[i] = enc(3, 0, 0, 8, 16'd204);
        imem[22] = enc(3, 0, 0, 6, 16'd140);
        imem[23] = enc(4, 9, 0, 0, 16'd0);
        imem[24] = enc(6, 0, 0, 0, 16'd4);
        for (int i = 25; i < 29; i++) imem[i] = enc(3, 0, 0, 8, 16'd204);
        imem[29] = enc(3, 0, 0, 9, 16'd144);
        imem[30] = enc(5, 10, 0, 0, 16'd2);
        imem[31] = enc(3, 0, 0, 10, 16'd148);
        imem[32] = enc(5, 10, 10, 0, 16'hFFFF);
        imem[33] = enc(6, 0, 0, 0, 16'd1);
        imem[34] = enc(7, 0, 0, 0, 16'd124);
        imem[35] = enc(3, 0, 0, 10, 16'd152);
        imem[36] = enc(7, 0, 0, 0, 16'd144);

        // R2 indexed load of word at 16+24, R4 store at literal 128
        push_exp(32'd128, 32'hDEAD_BEEF, "R2");
        // R4 negative literal: 16 + (-4), data is the R3 offset-load result
        push_exp(32'd12, 32'd7, "R3 R4");
        // R5 register add 7 + DEADBEEF; R7 untaken branch follows
        push_exp(32'd132, 32'hDEAD_BEF6, "R5");
        // R6 taken branch (zero flag kept through a load, R9) skips 200-stores
        push_exp(32'd136, 32'd100, "R6 R9");
        // R8 jump to r8 + 8 skips 204-stores; literal add 7 + (-7) gave 0
        push_exp(32'd140, 32'd0, "R8 R5");
        // R9 register add of zeros sets flag, branch skips 204-stores
        push_exp(32'd144, 32'd0, "R9");
        // R7 loop: first pass flag clear, branch falls through to jump
        push_exp(32'd148, 32'd2, "R7");
        push_exp(32'd148, 32'd1, "R7 R8");
        push_exp(32'd152, 32'd0, "R6");

        // R10 reset state
        repeat (3) @(negedge clk);
        check(imem_addr == 32'h0, "R10 reset pc", imem_addr, 32'h0);
        check(dmem_we == 1'b0, "R10 reset we", {31'h0, dmem_we}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < 1000 && exp_addr.size() != 0; i++) @(negedge clk);
        if (exp_addr.size() != 0) begin
            check(1'b0, "R1 watchdog", exp_addr.size(), 32'h0);
        end else begin
            check(1'b1, "R1 drained", 32'h0, 32'h0);
        end

        repeat (5) @(negedge clk);
        // R8 final self-jump holds the program counter
        check(imem_addr == 32'd144, "R8 halt pc", imem_addr, 32'd144);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule